// File: doc/BRIEF.md
# Mask-Bit Pixel Write Stage

This stage sits between a rasterizer's pixel stream and a 16-bit-per-pixel frame-buffer port. Each pixel arrives on a valid/ready input carrying a word address and a 16-bit colour. The stage decides whether and how that pixel reaches memory, based on the top bit (bit 15) of each stored word, which serves as a per-pixel protection flag.

Two mode bits are loaded by a configuration write. The force-flag mode ORs bit 15 into every colour the stage writes. The protect mode first reads the destination word and drops the write when that word already has bit 15 set. When protect mode is off, no read is made and pixels stream at one per cycle. When it is on, each pixel takes a read cycle and then a decision cycle. The stage also keeps running counts of pixels written and pixels dropped.

Top module: `mask_pixel_stage`

## Requirements
- R1: The configuration word is loaded when `cfg_we` is high. Bit 0 enables force-flag mode and bit 1 enables protect mode. The two bits act independently, and both are 0 after reset.
- R2: With force-flag on, every word written has bit 15 set. For example, colour 0x001F is stored as 0x801F.
- R3: With protect on, a pixel whose stored word has bit 15 set is dropped, and the stored word is unchanged (0x801F stays 0x801F when 0x03E0 targets it).
- R4: With protect on, a pixel whose stored word has bit 15 clear is written. Bit 15 is set only if force-flag is on, so with force-flag off, 0x03E0 is stored as 0x03E0.
- R5: With protect off, no memory read is issued. The write goes out in the cycle the pixel is accepted, and `pix_ready` stays high, so N pixels are accepted in N cycles.
- R6: With protect on, the read goes out in the acceptance cycle and the keep-or-drop decision (and any write) is made in the next cycle. `pix_ready` is low during that decision cycle, so N pixels take 2N cycles.
- R7: A pixel uses the mode that was in force when it was accepted. A configuration write in the same cycle as acceptance, or while a pixel is awaiting its decision, affects only later pixels.
- R8: `written_count` increments by one for each word written, and `rejected_count` increments by one for each pixel dropped.
- R9: After reset, `pix_ready` is high, no read or write is issued, and both counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Load mode bits from cfg_data |
| cfg_data | input | 2 | Bit 0 force-flag, bit 1 protect |
| pix_valid | input | 1 | Pixel offered |
| pix_ready | output | 1 | Pixel can be accepted this cycle |
| pix_addr | input | ADDR_W | Destination word address |
| pix_color | input | 16 | Pixel colour |
| mem_rd | output | 1 | Memory read strobe (data returns next cycle) |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, one cycle after mem_rd |
| written_count | output | CNT_W | Words written since reset |
| rejected_count | output | CNT_W | Pixels dropped since reset |

## Verification
Directed patterns exercise each mode on its own:
- force-flag alone on a fresh word, which shows the OR of bit 15;
- protect alone onto a flagged word and onto an unflagged word, which separates a drop from a plain write that gains no flag;
- streams under each mode, which separate the one-cycle path from the two-cycle path by cycle count and read count;
- configuration writes placed in the acceptance cycle and in the decision cycle, which show whether a mode is captured at acceptance or read late.

A seeded random run then mixes pixels and mode changes over a small address range. Stored words are random, with bit 15 random, so drops and writes interleave on the same addresses. Final memory and counters are compared with a bench reference model.

// File: rtl/mask_wr_pkg.sv
package mask_wr_pkg;

    localparam int PIX_W    = 16;
    localparam int FLAG_BIT = PIX_W - 1;
    localparam int CFG_W    = 2;

    // Field order matches the configuration word: bit 0 force, bit 1 protect.
    typedef struct packed {
        logic protect;
        logic force_flag;
    } mask_mode_t;

    typedef enum logic {
        ST_ACCEPT,
        ST_DECIDE
    } stage_t;

    typedef enum logic [1:0] {
        OUT_NONE,
        OUT_WRITE,
        OUT_DROP
    } outcome_t;

    function automatic logic [PIX_W-1:0] apply_flag(input logic [PIX_W-1:0] color,
                                                    input logic force_on);
        logic [PIX_W-1:0] res;
        res = color;
        if (force_on) res[FLAG_BIT] = 1'b1;
        return res;
    endfunction

endpackage

// File: rtl/mask_mode_reg.sv
module mask_mode_reg
    import mask_wr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_data,
    output mask_mode_t       mode_o
);

    mask_mode_t mode_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
        end else if (cfg_we) begin
            mode_q <= mask_mode_t'(cfg_data);
        end
    end

    assign mode_o = mode_q;

endmodule

// File: rtl/mask_seq.sv
module mask_seq
    import mask_wr_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  mask_mode_t        mode_i,
    input  logic              pix_valid,
    input  logic [ADDR_W-1:0] pix_addr,
    input  logic [PIX_W-1:0]  pix_color,
    output logic              pix_ready,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [PIX_W-1:0]  mem_wdata,
    input  logic [PIX_W-1:0]  mem_rdata,
    output outcome_t          outcome_o
);

    stage_t            state_q, state_d;
    logic [ADDR_W-1:0] hold_addr_q;
    logic [PIX_W-1:0]  hold_color_q;
    logic              hold_force_q;
    logic              accept;

    always_comb begin
        pix_ready = (state_q == ST_ACCEPT);
        accept    = pix_valid && pix_ready;
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        mem_addr  = pix_addr;
        mem_wdata = '0;
        outcome_o = OUT_NONE;
        state_d   = state_q;
        case (state_q)
            ST_ACCEPT: begin
                if (accept) begin
                    if (mode_i.protect) begin
                        mem_rd  = 1'b1;
                        state_d = ST_DECIDE;
                    end else begin
                        mem_wr    = 1'b1;
                        mem_wdata = apply_flag(pix_color, mode_i.force_flag);
                        outcome_o = OUT_WRITE;
                    end
                end
            end
            ST_DECIDE: begin
                mem_addr = hold_addr_q;
                state_d  = ST_ACCEPT;
                if (mem_rdata[FLAG_BIT]) begin
                    outcome_o = OUT_DROP;
                end else begin
                    mem_wr    = 1'b1;
                    mem_wdata = apply_flag(hold_color_q, hold_force_q);
                    outcome_o = OUT_WRITE;
                end
            end
            default: state_d = ST_ACCEPT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= ST_ACCEPT;
            hold_addr_q  <= '0;
            hold_color_q <= '0;
            hold_force_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept && mode_i.protect) begin
                hold_addr_q  <= pix_addr;
                hold_color_q <= pix_color;
                hold_force_q <= mode_i.force_flag;
            end
        end
    end

endmodule

// File: rtl/mask_counters.sv
module mask_counters
    import mask_wr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  outcome_t         outcome_i,
    output logic [CNT_W-1:0] written_count,
    output logic [CNT_W-1:0] rejected_count
);

    localparam int N_CNT = 2;

    logic [N_CNT-1:0] bump;
    logic [CNT_W-1:0] cnt_q [N_CNT];

    assign bump[0] = (outcome_i == OUT_WRITE);
    assign bump[1] = (outcome_i == OUT_DROP);

    for (genvar i = 0; i < N_CNT; i++) begin : g_cnt
        always_ff @(posedge clk) begin
            if (rst) begin
                cnt_q[i] <= '0;
            end else if (bump[i]) begin
                cnt_q[i] <= cnt_q[i] + CNT_W'(1);
            end
        end
    end

    assign written_count  = cnt_q[0];
    assign rejected_count = cnt_q[1];

endmodule

// File: rtl/mask_pixel_stage.sv
module mask_pixel_stage
    import mask_wr_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_data,
    input  logic              pix_valid,
    output logic              pix_ready,
    input  logic [ADDR_W-1:0] pix_addr,
    input  logic [15:0]       pix_color,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [15:0]       mem_wdata,
    input  logic [15:0]       mem_rdata,
    output logic [CNT_W-1:0]  written_count,
    output logic [CNT_W-1:0]  rejected_count
);

    mask_mode_t mode;
    outcome_t   outcome;
    logic       force_mode;
    logic       protect_mode;

    assign force_mode   = mode.force_flag;
    assign protect_mode = mode.protect;

    mask_mode_reg u_mode (
        .clk      (clk),
        .rst      (rst),
        .cfg_we   (cfg_we),
        .cfg_data (cfg_data),
        .mode_o   (mode)
    );

    mask_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .mode_i    (mode),
        .pix_valid (pix_valid),
        .pix_addr  (pix_addr),
        .pix_color (pix_color),
        .pix_ready (pix_ready),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .outcome_o (outcome)
    );

    mask_counters #(.CNT_W(CNT_W)) u_cnt (
        .clk            (clk),
        .rst            (rst),
        .outcome_i      (outcome),
        .written_count  (written_count),
        .rejected_count (rejected_count)
    );

endmodule

// File: rtl/mask_pixel_stage_chk.sv
module mask_pixel_stage_chk #(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              pix_valid,
    input logic              pix_ready,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [15:0]       mem_wdata,
    input logic [15:0]       mem_rdata,
    input logic [CNT_W-1:0]  written_count,
    input logic              force_mode,
    input logic              protect_mode
);

    AST_FAST_NO_READ: assert property (@(posedge clk) disable iff (rst)
        (pix_valid && pix_ready && !protect_mode) |-> (mem_wr && !mem_rd)); // R5

    AST_FORCE_FLAG: assert property (@(posedge clk) disable iff (rst)
        (pix_valid && pix_ready && !protect_mode && force_mode) |-> mem_wdata[15]); // R2

    AST_READY_LOW_DECIDE: assert property (@(posedge clk) disable iff (rst)
        mem_rd |=> !pix_ready); // R6

    AST_PROTECT_DROP: assert property (@(posedge clk) disable iff (rst)
        mem_rd |=> (mem_rdata[15] -> !mem_wr)); // R3

    AST_UNFLAGGED_FILL: assert property (@(posedge clk) disable iff (rst)
        mem_rd |=> (!mem_rdata[15] -> (mem_wr && mem_addr == $past(mem_addr)))); // R4

    AST_WRITE_COUNT: assert property (@(posedge clk) disable iff (rst)
        mem_wr |=> (written_count - $past(written_count)) == CNT_W'(1)); // R8

endmodule

bind mask_pixel_stage mask_pixel_stage_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .pix_valid     (pix_valid),
    .pix_ready     (pix_ready),
    .mem_rd        (mem_rd),
    .mem_wr        (mem_wr),
    .mem_addr      (mem_addr),
    .mem_wdata     (mem_wdata),
    .mem_rdata     (mem_rdata),
    .written_count (written_count),
    .force_mode    (force_mode),
    .protect_mode  (protect_mode)
);

// File: tb/tb_mask_pixel_stage.sv
module tb_mask_pixel_stage;

    localparam int ADDR_W = 8;
    localparam int CNT_W  = 16;
    localparam int DEPTH  = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst;
    logic              cfg_we;
    logic [1:0]        cfg_data;
    logic              pix_valid;
    logic              pix_ready;
    logic [ADDR_W-1:0] pix_addr;
    logic [15:0]       pix_color;
    logic              mem_rd, mem_wr;
    logic [ADDR_W-1:0] mem_addr;
    logic [15:0]       mem_wdata;
    logic [15:0]       mem_rdata;
    logic [CNT_W-1:0]  written_count, rejected_count;

    logic              ld_en;
    logic [ADDR_W-1:0] ld_addr;
    logic [15:0]       ld_data;
    logic [15:0]       mem [DEPTH];
    logic [15:0]       ref_mem [DEPTH];

    int  checks = 0;
    int  errors = 0;
    int  cyc = 0;
    int  rd_seen = 0;
    int  wr_seen = 0;
    int  ref_wr = 0;
    int  ref_rej = 0;
    bit  ref_force = 0;
    bit  ref_protect = 0;
    bit  done = 0;

    always #4 clk = ~clk;

    mask_pixel_stage #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) dut (
        .clk (clk), .rst (rst), .cfg_we (cfg_we), .cfg_data (cfg_data),
        .pix_valid (pix_valid), .pix_ready (pix_ready), .pix_addr (pix_addr),
        .pix_color (pix_color), .mem_rd (mem_rd), .mem_wr (mem_wr),
        .mem_addr (mem_addr), .mem_wdata (mem_wdata), .mem_rdata (mem_rdata),
        .written_count (written_count), .rejected_count (rejected_count)
    );

    // Behavioural frame-buffer: registered read, write visible to next read.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mem_rd) rd_seen <= rd_seen + 1;
        if (mem_wr) wr_seen <= wr_seen + 1;
        if (ld_en) mem[ld_addr] <= ld_data;
        else if (mem_wr) mem[mem_addr] <= mem_wdata;
        if (mem_rd) mem_rdata <= mem[mem_addr];
    end

    function automatic logic [15:0] model_word(input logic [15:0] c, input bit f);
        return f ? (c | 16'h8000) : c;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic preload(input int a, input logic [15:0] d);
        @(negedge clk);
        pix_valid = 1'b0;
        ld_en = 1'b1; ld_addr = ADDR_W'(a); ld_data = d;
        @(negedge clk);
        ld_en = 1'b0;
        ref_mem[a] = d;
    endtask

    task automatic model_accept(input int a, input logic [15:0] c);
        if (ref_protect && ref_mem[a][15]) begin
            ref_rej++;
        end else begin
            ref_mem[a] = model_word(c, ref_force);
            ref_wr++;
        end
    endtask

    // Offer a pixel; returns at the negedge before the accepting edge.
    task automatic send(input int a, input logic [15:0] c);
        @(negedge clk);
        cfg_we = 1'b0;
        pix_valid = 1'b1; pix_addr = ADDR_W'(a); pix_color = c;
        while (!pix_ready) @(negedge clk);
        model_accept(a, c);
    endtask

    task automatic set_mode(input logic [1:0] v);
        @(negedge clk);
        pix_valid = 1'b0;
        cfg_we = 1'b1; cfg_data = v;
        ref_force = v[0]; ref_protect = v[1];
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic drain();
        @(negedge clk);
        pix_valid = 1'b0; cfg_we = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic check_word(input int a, input logic [15:0] exp, input string req);
        check(mem[a] === exp, req, $sformatf("word @%0d", a), int'(mem[a]), int'(exp));
    endtask

    task automatic check_counts(input string req);
        check(written_count == CNT_W'(ref_wr), req, "written_count",
              int'(written_count), ref_wr);
        check(rejected_count == CNT_W'(ref_rej), req, "rejected_count",
              int'(rejected_count), ref_rej);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int c0, r0, w0;
        rst = 1'b1; cfg_we = 1'b0; cfg_data = '0; pix_valid = 1'b0;
        pix_addr = '0; pix_color = '0; ld_en = 1'b0; ld_addr = '0; ld_data = '0;
        void'($urandom(32'd20260515));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R9: reset state
        check(pix_ready === 1'b1, "R9", "pix_ready", int'(pix_ready), 1);
        check(mem_rd === 1'b0 && mem_wr === 1'b0, "R9", "rd|wr", int'({mem_rd, mem_wr}), 0);
        check(written_count == '0 && rejected_count == '0, "R9", "counts",
              int'(written_count) + int'(rejected_count), 0);

        // R1/R2: force-flag only; red gains bit 15
        preload(1, 16'h1234);
        preload(5, 16'h1234);
        set_mode(2'b01);
        send(1, 16'h001F);
        drain();
        check_word(1, 16'h801F, "R2");

        // R1/R3: protect only; flagged word kept
        set_mode(2'b10);
        send(1, 16'h03E0);
        drain();
        check_word(1, 16'h801F, "R3");
        // R4: unflagged word written, no flag added by protect alone
        send(5, 16'h03E0);
        drain();
        check_word(5, 16'h03E0, "R4");
        check_counts("R8");

        // R1: both modes together
        preload(6, 16'h0000);
        set_mode(2'b11);
        send(6, 16'h7C00);
        drain();
        check_word(6, 16'hFC00, "R1");

        // R5: streaming without protect, one pixel per cycle, no reads
        set_mode(2'b00);
        @(negedge clk);
        c0 = cyc; r0 = rd_seen; w0 = wr_seen;
        for (int i = 0; i < 8; i++) send(64 + i, 16'(16'h0100 + i));
        @(negedge clk);
        pix_valid = 1'b0;
        check(cyc - c0 == 9, "R5", "cycles for 8 pixels", cyc - c0, 9);
        check(rd_seen - r0 == 0, "R5", "reads", rd_seen - r0, 0);
        check(wr_seen - w0 == 8, "R5", "writes", wr_seen - w0, 8);
        drain();
        check_word(71, 16'h0107, "R5");

        // R6: streaming with protect, two cycles per pixel
        for (int i = 0; i < 4; i++) preload(80 + i, (i == 2) ? 16'h8001 : 16'h0001);
        set_mode(2'b10);
        @(negedge clk);
        c0 = cyc; r0 = rd_seen;
        for (int i = 0; i < 4; i++) send(80 + i, 16'h0055);
        @(negedge clk);
        pix_valid = 1'b0;
        check(cyc - c0 == 8, "R6", "cycles for 4 pixels", cyc - c0, 8);
        check(rd_seen - r0 == 4, "R6", "reads", rd_seen - r0, 4);
        drain();
        check_word(82, 16'h8001, "R6");
        check_word(83, 16'h0055, "R6");

        // R7: configuration write in the acceptance cycle uses old mode
        preload(40, 16'h8000);
        preload(41, 16'h8000);
        set_mode(2'b00);
        @(negedge clk);
        cfg_we = 1'b1; cfg_data = 2'b11;
        pix_valid = 1'b1; pix_addr = 8'd40; pix_color = 16'h001F;
        model_accept(40, 16'h001F);
        ref_force = 1; ref_protect = 1;
        send(41, 16'h001F);
        drain();
        check_word(40, 16'h001F, "R7");
        check_word(41, 16'h8000, "R7");

        // R7: configuration write while a pixel awaits its decision
        preload(42, 16'h0000);
        send(42, 16'h03E0);
        @(negedge clk);
        cfg_we = 1'b1; cfg_data = 2'b00; pix_valid = 1'b0;
        @(negedge clk);
        cfg_we = 1'b0;
        ref_force = 0; ref_protect = 0;
        drain();
        check_word(42, 16'h83E0, "R7");
        check_counts("R8");

        // Random mix over a small address window
        for (int a = 0; a < 16; a++) preload(a, 16'($urandom));
        for (int n = 0; n < 300; n++) begin
            int k;
            k = int'($urandom_range(0, 9));
            if (k == 0) set_mode(2'($urandom));
            else if (k == 1) drain();
            else send(int'($urandom_range(0, 15)), 16'($urandom));
        end
        drain();
        for (int a = 0; a < 16; a++) check_word(a, ref_mem[a], "R3/R4 random");
        check_counts("R8");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule